// File: doc/BRIEF.md
# Packed Pixel Format Unpacker

This block sits behind the byte-level receive logic of a serial camera link and turns the payload bytes of each packet back into individual pixels. A packet opens with a one-cycle start pulse that carries a three-bit format code. The payload bytes then follow, one per cycle, each with a valid strobe. A one-cycle end pulse closes the packet. The block rebuilds each pixel from its packed layout: plain 8-bit, 10-bit with the low bits gathered into a trailing byte, 12-bit with shared low nibbles, 7-bit packed bit-serially, and 24-bit colour triplets. Each pixel leaves on a 24-bit bus, zero-extended and qualified by a pixel-valid strobe.

The output has no backpressure. It feeds a rate-matching FIFO that is assumed to absorb everything. Some groups finish several pixels in one cycle, so complete pixels wait in a short internal queue and leave one per cycle, in order. If a packet ends in the middle of a group, the partial bytes are discarded and a one-cycle error pulse is raised. Start, end and byte-valid never coincide in a cycle. In 7-bit mode, the source leaves at least one idle cycle after every seventh byte, because such a group yields eight pixels.

Top module: `pix_unpack_top`

## Requirements
- R1: While reset is held low, and after its release until the first pixel, pixValid, pixData and errFlag are all zero.
- R2: Format code 0 (8-bit) turns each byte into one pixel {16'b0, byte}. With the queue empty, the pixel is valid after the second rising edge following the edge that samples the byte.
- R3: Format code 1 (10-bit) takes groups of 5 bytes and yields 4 pixels. Pixel k is {14'b0, byte k, byte4[2k+1:2k]} for k = 0..3.
- R4: Format code 2 (12-bit) takes groups of 3 bytes and yields 2 pixels: {12'b0, byte0, byte2[3:0]} and {12'b0, byte1, byte2[7:4]}.
- R5: Format code 3 (7-bit) treats 7 bytes as a 56-bit stream, with byte i in bits 8i+7..8i. Pixel k is bits 7k+6..7k, zero-extended. It is emitted as soon as its last bit has arrived.
- R6: Format code 4 (24-bit colour) turns every 3 bytes into one pixel {byte2, byte1, byte0}.
- R7: Pixels leave in arrival order, at most one per cycle, every cycle while any are pending. pixData is zero whenever pixValid is low.
- R8: The format code is sampled only on the packet-start pulse. Its value in any other cycle has no effect.
- R9: A packet-start pulse restarts grouping at byte 0 and silently drops a partial group.
- R10: An end pulse arriving mid-group drops the partial bytes and raises errFlag for exactly one cycle, on the edge after the end pulse. An end at a group boundary raises no error.
- R11: Bytes received under format codes 5 to 7, or before any packet start, produce no pixels and no error.
- R12: Under the stated input rules, the pending-pixel queue of QDEPTH entries never overflows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pktStart | input | 1 | Packet start pulse; samples fmtCode |
| pktEnd | input | 1 | Packet end pulse |
| fmtCode | input | 3 | Pixel format code of the starting packet |
| byteValid | input | 1 | Payload byte present |
| byteData | input | 8 | Payload byte |
| pixValid | output | 1 | Pixel present on pixData |
| pixData | output | 24 | Zero-extended pixel |
| errFlag | output | 1 | One-cycle pulse: packet ended mid-group |

## Verification
Every format is driven with random bytes over several whole groups. The low bits, nibbles and colour components therefore differ from pixel to pixel, which exposes any swapped lane, shift or byte order. The 7-bit runs stop for one idle cycle at each group boundary, so the double-pixel completion at the seventh byte is seen draining. Some packets end after a whole group and some part-way through. Others are restarted mid-group, carry junk format codes between start pulses, or use unassigned codes. These tell the error pulse apart from a clean end, and show that the format latch and the phase reset behave as required.

// File: rtl/pix_unpack_pkg.sv
package pix_unpack_pkg;
  localparam int PIX_W = 24;
  localparam int MAX_PUSH = 4;
  localparam int HELD_N = 7;

  localparam logic [2:0] FMT_RAW8  = 3'd0;
  localparam logic [2:0] FMT_RAW10 = 3'd1;
  localparam logic [2:0] FMT_RAW12 = 3'd2;
  localparam logic [2:0] FMT_RAW7  = 3'd3;
  localparam logic [2:0] FMT_RGB   = 3'd4;
  localparam logic [2:0] FMT_NONE  = 3'd7;

  typedef struct packed {
    logic       capture;
    logic       last;
    logic [2:0] slot;
    logic [2:0] fmt;
  } ctrlStrb_t;

  function automatic logic [2:0] groupLen(input logic [2:0] f);
    case (f)
      FMT_RAW8:  return 3'd1;
      FMT_RAW10: return 3'd5;
      FMT_RAW12: return 3'd3;
      FMT_RAW7:  return 3'd7;
      FMT_RGB:   return 3'd3;
      default:   return 3'd0;
    endcase
  endfunction
endpackage

// File: rtl/pix_unpack_ctrl.sv
module pix_unpack_ctrl
  import pix_unpack_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       pktStart,
  input  logic       pktEnd,
  input  logic [2:0] fmtCode,
  input  logic       byteValid,
  output ctrlStrb_t  strb,
  output logic       errFlag
);
  logic [2:0] fmtQ;
  logic [2:0] phase;
  logic [2:0] len;
  logic       known;

  assign len   = groupLen(fmtQ);
  assign known = (len != 3'd0);

  always_comb begin
    strb.capture = byteValid && known;
    strb.last    = strb.capture && (phase == len - 3'd1);
    strb.slot    = phase;
    strb.fmt     = fmtQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fmtQ    <= FMT_NONE;
      phase   <= '0;
      errFlag <= 1'b0;
    end else begin
      errFlag <= pktEnd && (phase != 3'd0);
      if (pktStart) begin
        fmtQ  <= fmtCode;
        phase <= '0;
      end else if (pktEnd) begin
        phase <= '0;
      end else if (strb.capture) begin
        phase <= strb.last ? 3'd0 : phase + 3'd1;
      end
    end
  end

  // R9: a start pulse always leaves the grouping at byte 0
  p_start_clears_r9: assert property (@(posedge clk) disable iff (!rstN)
    pktStart |=> (phase == 3'd0));

  // R11: bytes under an unassigned format do not advance grouping
  p_ignore_unknown_r11: assert property (@(posedge clk) disable iff (!rstN)
    (byteValid && !known && !pktStart && !pktEnd) |=> (phase == $past(phase)));

  // R10: an error pulse is only seen once grouping has been cleared
  p_err_after_clear_r10: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |-> (phase == 3'd0 || $past(pktStart) || $past(strb.capture)));

  // R8: format only changes on a start pulse
  p_fmt_latched_r8: assert property (@(posedge clk) disable iff (!rstN)
    !pktStart |=> (fmtQ == $past(fmtQ)));
endmodule

// File: rtl/pix_unpack_dp.sv
module pix_unpack_dp
  import pix_unpack_pkg::*;
#(
  parameter int QDEPTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrb_t        strb,
  input  logic [7:0]       byteData,
  output logic             pixValid,
  output logic [PIX_W-1:0] pixData
);
  localparam int CNT_W = $clog2(QDEPTH + MAX_PUSH + 1);

  logic [7:0]       held [HELD_N];
  logic [PIX_W-1:0] q    [QDEPTH];
  logic [PIX_W-1:0] qN   [QDEPTH];
  logic [CNT_W-1:0] qCnt, qCntN, afterPop, newCnt;
  logic [PIX_W-1:0] newPix [MAX_PUSH];
  logic [55:0]      bits7, shifted7;

  // pixel assembly from the held bytes and the current byte
  always_comb begin
    for (int k = 0; k < MAX_PUSH; k++) newPix[k] = '0;
    newCnt = '0;
    for (int j = 0; j < HELD_N; j++) begin
      if (j < int'(strb.slot))       bits7[8*j +: 8] = held[j];
      else if (j == int'(strb.slot)) bits7[8*j +: 8] = byteData;
      else                           bits7[8*j +: 8] = 8'h00;
    end
    shifted7 = bits7 >> (7 * int'(strb.slot));
    if (strb.capture) begin
      case (strb.fmt)
        FMT_RAW8: begin
          newPix[0] = {16'b0, byteData};
          newCnt = CNT_W'(1);
        end
        FMT_RAW10: if (strb.last) begin
          for (int k = 0; k < 4; k++)
            newPix[k] = {14'b0, held[k], byteData[2*k +: 2]};
          newCnt = CNT_W'(4);
        end
        FMT_RAW12: if (strb.last) begin
          newPix[0] = {12'b0, held[0], byteData[3:0]};
          newPix[1] = {12'b0, held[1], byteData[7:4]};
          newCnt = CNT_W'(2);
        end
        FMT_RGB: if (strb.last) begin
          newPix[0] = {byteData, held[1], held[0]};
          newCnt = CNT_W'(1);
        end
        FMT_RAW7: begin
          newPix[0] = {17'b0, shifted7[6:0]};
          if (strb.last) begin
            newPix[1] = {17'b0, bits7[55:49]};
            newCnt = CNT_W'(2);
          end else begin
            newCnt = CNT_W'(1);
          end
        end
        default: newCnt = '0;
      endcase
    end
  end

  // pending-pixel queue: pop head, then append completed pixels
  always_comb begin
    for (int i = 0; i < QDEPTH; i++) qN[i] = q[i];
    afterPop = qCnt;
    if (qCnt != '0) begin
      for (int i = 0; i < QDEPTH - 1; i++) qN[i] = q[i+1];
      afterPop = qCnt - CNT_W'(1);
    end
    for (int i = 0; i < QDEPTH; i++)
      for (int k = 0; k < MAX_PUSH; k++)
        if (k < int'(newCnt) && i == int'(afterPop) + k) qN[i] = newPix[k];
    qCntN = afterPop + newCnt;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      qCnt     <= '0;
      pixValid <= 1'b0;
      pixData  <= '0;
      for (int i = 0; i < QDEPTH; i++) q[i] <= '0;
      for (int j = 0; j < HELD_N; j++) held[j] <= '0;
    end else begin
      qCnt     <= qCntN;
      pixValid <= (qCnt != '0);
      pixData  <= (qCnt != '0) ? q[0] : '0;
      for (int i = 0; i < QDEPTH; i++) q[i] <= qN[i];
      if (strb.capture) held[strb.slot] <= byteData;
    end
  end

  // R12: appended pixels always fit in the queue
  p_no_overflow_r12: assert property (@(posedge clk) disable iff (!rstN)
    (int'(afterPop) + int'(newCnt)) <= QDEPTH);

  // R2: an 8-bit byte into an empty queue is out two edges later
  p_raw8_latency_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.capture && strb.fmt == FMT_RAW8 && qCnt == '0)
      |=> ##1 (pixValid && pixData == {16'b0, $past(byteData, 2)}));

  // R7: an empty queue gives no pixel on the next cycle
  p_empty_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    (qCnt == '0) |=> (!pixValid && pixData == '0));

  // R7: pending pixels are drained without gaps
  p_drain_r7: assert property (@(posedge clk) disable iff (!rstN)
    (qCnt != '0) |=> pixValid);
endmodule

// File: rtl/pix_unpack_top.sv
module pix_unpack_top
  import pix_unpack_pkg::*;
#(
  parameter int QDEPTH = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        pktStart,
  input  logic        pktEnd,
  input  logic [2:0]  fmtCode,
  input  logic        byteValid,
  input  logic [7:0]  byteData,
  output logic        pixValid,
  output logic [23:0] pixData,
  output logic        errFlag
);
  ctrlStrb_t strb;

  pix_unpack_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .pktStart(pktStart), .pktEnd(pktEnd),
    .fmtCode(fmtCode), .byteValid(byteValid), .strb(strb), .errFlag(errFlag)
  );

  pix_unpack_dp #(.QDEPTH(QDEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .byteData(byteData),
    .pixValid(pixValid), .pixData(pixData)
  );
endmodule

// File: tb/tb_pix_unpack_top.sv
module tb_pix_unpack_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pktStart = 1'b0, pktEnd = 1'b0, byteValid = 1'b0;
  logic [2:0]  fmtCode = 3'd0;
  logic [7:0]  byteData = 8'h00;
  logic        pixValid, errFlag;
  logic [23:0] pixData;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  pix_unpack_top dut (
    .clk(clk), .rstN(rstN), .pktStart(pktStart), .pktEnd(pktEnd),
    .fmtCode(fmtCode), .byteValid(byteValid), .byteData(byteData),
    .pixValid(pixValid), .pixData(pixData), .errFlag(errFlag)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // ---------------- behavioural reference model ----------------
  logic [23:0] mq[$];
  string       tq[$];
  logic [7:0]  grp[$];
  longint      acc;
  int          nb, cnt7, mFmt;
  string       curTag = "R1";
  logic        expValid = 1'b0, expErr = 1'b0;
  logic [23:0] expData = '0;
  string       expTag = "R7";

  function automatic int inGrp();
    return (mFmt == 3) ? cnt7 : grp.size();
  endfunction

  task automatic clearGroup();
    grp.delete(); acc = 0; nb = 0; cnt7 = 0;
  endtask

  task automatic pushPix(input logic [23:0] p);
    mq.push_back(p); tq.push_back(curTag);
  endtask

  task automatic modelByte(input logic [7:0] b);
    case (mFmt)
      0: pushPix({16'b0, b});
      1: begin
        grp.push_back(b);
        if (grp.size() == 5) begin
          for (int k = 0; k < 4; k++) pushPix({14'b0, grp[k], grp[4][2*k +: 2]});
          grp.delete();
        end
      end
      2: begin
        grp.push_back(b);
        if (grp.size() == 3) begin
          pushPix({12'b0, grp[0], grp[2][3:0]});
          pushPix({12'b0, grp[1], grp[2][7:4]});
          grp.delete();
        end
      end
      3: begin
        acc = acc | (longint'(b) << nb);
        nb  = nb + 8;
        cnt7++;
        while (nb >= 7) begin
          pushPix({17'b0, 7'(acc & 64'h7f)});
          acc = acc >> 7;
          nb  = nb - 7;
        end
        if (cnt7 == 7) cnt7 = 0;
      end
      4: begin
        grp.push_back(b);
        if (grp.size() == 3) begin
          pushPix({grp[2], grp[1], grp[0]});
          grp.delete();
        end
      end
      default: ;
    endcase
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mq.delete(); tq.delete(); clearGroup(); mFmt = 7;
      expValid <= 1'b0; expData <= '0; expErr <= 1'b0;
    end else begin
      if (mq.size() > 0) begin
        expValid <= 1'b1; expData <= mq.pop_front(); expTag <= tq.pop_front();
      end else begin
        expValid <= 1'b0; expData <= '0; expTag <= "R7";
      end
      expErr <= pktEnd && (inGrp() != 0);
      if (pktStart) begin mFmt = int'(fmtCode); clearGroup(); end
      else if (pktEnd) clearGroup();
      else if (byteValid && mFmt <= 4) modelByte(byteData);
    end
  end

  // ---------------- comparison on every cycle ----------------
  always @(negedge clk) begin
    if (rstN && !done) begin
      checks++;
      if (pixValid !== expValid || pixData !== expData) begin
        fails++;
        $display("FAIL %s pixel: actual valid=%0b data=%06h expected valid=%0b data=%06h",
                 expTag, pixValid, pixData, expValid, expData);
      end
      checks++;
      if (errFlag !== expErr) begin
        fails++;
        $display("FAIL R10 errFlag: actual %0b expected %0b", errFlag, expErr);
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic idle();
    @(negedge clk);
    pktStart = 0; pktEnd = 0; byteValid = 0; fmtCode = 3'($urandom); byteData = 8'h00;
  endtask

  task automatic startPkt(input logic [2:0] f, input string tag);
    @(negedge clk);
    curTag = tag;
    pktStart = 1; pktEnd = 0; byteValid = 0; fmtCode = f;
  endtask

  task automatic endPkt();
    @(negedge clk);
    pktStart = 0; pktEnd = 1; byteValid = 0; fmtCode = 3'($urandom);
  endtask

  // fmtCode carries junk on byte cycles (R8)
  task automatic sendBytes(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      pktStart = 0; pktEnd = 0; byteValid = 1;
      fmtCode = 3'($urandom); byteData = 8'($urandom);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    @(negedge clk);
    done = 1'b1;
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (4) begin
      @(negedge clk);
      checks++;
      if (pixValid !== 1'b0 || pixData !== 24'h0 || errFlag !== 1'b0) begin
        fails++;
        $display("FAIL R1 reset: actual v=%0b d=%06h e=%0b expected 0 0 0", pixValid, pixData, errFlag);
      end
    end
    rstN = 1'b1;
    // R11: bytes before any packet start are ignored
    curTag = "R11"; sendBytes(3); idle();
    // R2: 8-bit
    startPkt(3'd0, "R2"); sendBytes(6); endPkt();
    // R3: 10-bit, two back-to-back groups
    startPkt(3'd1, "R3"); sendBytes(10); endPkt();
    // R4: 12-bit
    startPkt(3'd2, "R4"); sendBytes(9); endPkt();
    // R5 and R12: 7-bit with one idle cycle per group keeps the queue bounded
    startPkt(3'd3, "R5"); sendBytes(7); idle(); sendBytes(7); idle(); endPkt();
    // R6: colour triplets
    startPkt(3'd4, "R6"); sendBytes(6); endPkt();
    // R8: junk codes between starts must not change the format
    startPkt(3'd1, "R8"); sendBytes(5); idle(); sendBytes(5); endPkt();
    // R9: restart in the middle of a group
    startPkt(3'd2, "R9"); sendBytes(2); startPkt(3'd2, "R9"); sendBytes(3); endPkt();
    startPkt(3'd1, "R9"); sendBytes(4); startPkt(3'd4, "R9"); sendBytes(3); endPkt();
    // R10: ends mid-group raise the error, clean ends do not
    startPkt(3'd1, "R10"); sendBytes(3); endPkt(); idle();
    startPkt(3'd3, "R10"); sendBytes(4); endPkt(); idle();
    startPkt(3'd2, "R10"); sendBytes(4); endPkt(); idle();
    startPkt(3'd0, "R10"); sendBytes(2); endPkt(); idle();
    // R11: unassigned format codes
    startPkt(3'd6, "R11"); sendBytes(4); endPkt();
    startPkt(3'd5, "R11"); sendBytes(3); endPkt();
    // R7: drain and idle
    repeat (10) idle();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule